// File: doc/BRIEF.md
# Register-Pair Arithmetic Right Shifter

This block shifts a 64-bit signed value right by a variable amount, where the value is held in two 32-bit registers. The even register supplies the upper word and the following odd register supplies the lower word. The shift amount is not given directly. The block forms an effective address from an optional base-register value plus a 12-bit displacement, and it uses the low 6 bits of that sum as the count. No memory is read.

A caller presents both register words, the base value with its presence flag, the displacement and a flag marking an odd first-operand register. It then pulses `start` for one cycle. On the next cycle `done` pulses and the result is on the outputs: the shifted upper and lower words and a 2-bit condition code describing the signed result. The outputs hold until the next `start`.

If the register flag marks an odd register, the request is refused. The block raises a specification error, returns the operand words unaltered and leaves the condition code as it was.

Top module: `pair_sra_unit`

## Requirements
- R1: The operand is the 64-bit value {hi_in, lo_in}, with hi_in as bits 63..32. The result appears as hi_out (bits 63..32) and lo_out (bits 31..0).
- R2: With base_present=1 the count is bits 5..0 of the 32-bit sum base_val + zero-extended disp. The sum wraps on carry-out, and carries into bit 6 and all higher address bits have no effect.
- R3: With base_present=0 the count is disp[5:0], whatever the value of base_val. Displacement bits 11..6 have no effect.
- R4: The shift is arithmetic and to the right. Bits leaving bit 0 are lost, vacated upper positions take the original bit 63, and bit 63 of the result equals bit 63 of the operand.
- R5: Counts from 32 to 63 are exact. A count of 32 moves hi_in into lo_out and fills hi_out with the sign. A count of 63 makes every result bit equal to the sign.
- R6: After a shift, cc is 0 when the 64-bit result is zero, 1 when it is negative and 2 when it is positive. Code 3 never appears.
- R7: done is 1 in exactly the cycle after a cycle with start=1. Without start, hi_out, lo_out and cc keep their values.
- R8: A request with reg_odd=1 sets spec_err=1 alongside done, gives hi_out=hi_in and lo_out=lo_in, and leaves cc unchanged. The next request with reg_odd=0 clears spec_err.
- R9: After reset, done=0, spec_err=0, hi_out=0, lo_out=0 and cc=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; operands are sampled in this cycle |
| reg_odd | input | 1 | First-operand register number is odd |
| hi_in | input | 32 | Even register contents (upper word) |
| lo_in | input | 32 | Odd register contents (lower word) |
| base_present | input | 1 | A base register takes part in the address |
| base_val | input | 32 | Base register contents |
| disp | input | 12 | Displacement |
| done | output | 1 | Result valid pulse |
| hi_out | output | 32 | Result upper word |
| lo_out | output | 32 | Result lower word |
| cc | output | 2 | Condition code: 0 zero, 1 negative, 2 positive |
| spec_err | output | 1 | Odd register refused |

## Verification
The hardest case to reach from the ports is a count that differs from the visible displacement. This happens when the base-plus-displacement sum carries into bit 6 or out of bit 31, and it is the only way a wrong adder width or a wrong bit slice shows up. The stimulus sets up such sums on purpose: a base of 60 with a displacement of 8 gives a count of 4, and a base of all ones with a displacement of 5 wraps to 4. Other vectors put nonzero base values and high displacement bits where they must have no effect. The counts 31, 32, 33 and 63 are aimed at the largest stage of the shifter and at its combination with the smaller stages.

// File: rtl/pair_sra_pkg.sv
package pair_sra_pkg;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2
    } cc_code_e;

endpackage

// File: rtl/psu_eff_addr.sv
module psu_eff_addr #(
    parameter int ADDR_W  = 32,
    parameter int DISP_W  = 12,
    parameter int COUNT_W = 6
) (
    input  logic               base_present,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [DISP_W-1:0]  disp,
    output logic [COUNT_W-1:0] count
);

    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] disp_term;
    logic [ADDR_W-1:0] ea;

    always_comb begin
        base_term = base_present ? base_val : '0;
        disp_term = ADDR_W'(disp);
        ea        = base_term + disp_term;
        count     = ea[COUNT_W-1:0];
    end

    // R3
    always_comb begin
        no_base_ea_chk: assert (base_present || ea == ADDR_W'(disp));
    end

endmodule

// File: rtl/psu_barrel.sv
module psu_barrel #(
    parameter int DATA_W  = 64,
    parameter int COUNT_W = 6
) (
    input  logic [DATA_W-1:0]  din,
    input  logic [COUNT_W-1:0] count,
    output logic [DATA_W-1:0]  dout
);

    logic                           sign_bit;
    logic [COUNT_W:0][DATA_W-1:0]   stage;

    assign sign_bit = din[DATA_W-1];
    assign stage[0] = din;

    for (genvar k = 0; k < COUNT_W; k++) begin : g_stage
        localparam int SH = 1 << k;
        always_comb begin
            if (count[k]) begin
                stage[k+1] = {{SH{sign_bit}}, stage[k][DATA_W-1:SH]};
            end else begin
                stage[k+1] = stage[k];
            end
        end
    end

    assign dout = stage[COUNT_W];

    // R4
    always_comb begin
        zero_count_pass_chk: assert (count != '0 || dout == din);
    end

endmodule

// File: rtl/psu_cond.sv
module psu_cond
    import pair_sra_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] value,
    output cc_code_e          code
);

    always_comb begin
        if (value == '0) begin
            code = CC_ZERO;
        end else if (value[DATA_W-1]) begin
            code = CC_NEG;
        end else begin
            code = CC_POS;
        end
    end

endmodule

// File: rtl/pair_sra_unit.sv
module pair_sra_unit
    import pair_sra_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DISP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              reg_odd,
    input  logic [WORD_W-1:0] hi_in,
    input  logic [WORD_W-1:0] lo_in,
    input  logic              base_present,
    input  logic [WORD_W-1:0] base_val,
    input  logic [DISP_W-1:0] disp,
    output logic              done,
    output logic [WORD_W-1:0] hi_out,
    output logic [WORD_W-1:0] lo_out,
    output logic [1:0]        cc,
    output logic              spec_err
);

    localparam int DATA_W  = 2 * WORD_W;
    localparam int COUNT_W = $clog2(DATA_W);

    typedef struct packed {
        logic              done;
        logic              spec_err;
        logic [1:0]        cc;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } unit_state_t;

    unit_state_t        st_d, st_q;
    logic [COUNT_W-1:0] count;
    logic [DATA_W-1:0]  shifted;
    cc_code_e           res_code;

    psu_eff_addr #(
        .ADDR_W  (WORD_W),
        .DISP_W  (DISP_W),
        .COUNT_W (COUNT_W)
    ) i_eff_addr (
        .base_present (base_present),
        .base_val     (base_val),
        .disp         (disp),
        .count        (count)
    );

    psu_barrel #(
        .DATA_W  (DATA_W),
        .COUNT_W (COUNT_W)
    ) i_barrel (
        .din   ({hi_in, lo_in}),
        .count (count),
        .dout  (shifted)
    );

    psu_cond #(
        .DATA_W (DATA_W)
    ) i_cond (
        .value (shifted),
        .code  (res_code)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        if (start) begin
            if (reg_odd) begin
                st_d.spec_err = 1'b1;
                st_d.hi       = hi_in;
                st_d.lo       = lo_in;
            end else begin
                st_d.spec_err = 1'b0;
                st_d.hi       = shifted[DATA_W-1:WORD_W];
                st_d.lo       = shifted[WORD_W-1:0];
                st_d.cc       = res_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done     = st_q.done;
    assign spec_err = st_q.spec_err;
    assign cc       = st_q.cc;
    assign hi_out   = st_q.hi;
    assign lo_out   = st_q.lo;

    // R7
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!done && $stable(hi_out) && $stable(lo_out) && $stable(cc)));

    // R4
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !reg_odd) |=> (hi_out[WORD_W-1] == $past(hi_in[WORD_W-1])));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cc != 2'd3));

    // R6
    neg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !spec_err && hi_out[WORD_W-1]) |-> (cc == 2'd1));

    // R8
    odd_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && reg_odd) |=> (spec_err && $stable(cc) &&
                                hi_out == $past(hi_in) && lo_out == $past(lo_in)));

endmodule

// File: tb/test_pair_sra_unit.sv
`timescale 1ns/1ps
module test_pair_sra_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        reg_odd = 1'b0;
    logic [31:0] hi_in = '0;
    logic [31:0] lo_in = '0;
    logic        base_present = 1'b0;
    logic [31:0] base_val = '0;
    logic [11:0] disp = '0;
    logic        done;
    logic [31:0] hi_out;
    logic [31:0] lo_out;
    logic [1:0]  cc;
    logic        spec_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pair_sra_unit i_pair_sra_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .reg_odd      (reg_odd),
        .hi_in        (hi_in),
        .lo_in        (lo_in),
        .base_present (base_present),
        .base_val     (base_val),
        .disp         (disp),
        .done         (done),
        .hi_out       (hi_out),
        .lo_out       (lo_out),
        .cc           (cc),
        .spec_err     (spec_err)
    );

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
        logic        bp;
        logic [31:0] base;
        logic [11:0] dsp;
        logic [31:0] ehi;
        logic [31:0] elo;
        logic [1:0]  ecc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        // R4 R6: shift by 1, negative
        '{32'hFFFFFFF0, 32'hF0F0F0F0, 1'b0, 32'h0, 12'd1,  32'hFFFFFFF8, 32'h78787878, 2'd1},
        // R4: shift by 2
        '{32'hFFFFFFF0, 32'hF0F0F0F0, 1'b0, 32'h0, 12'd2,  32'hFFFFFFFC, 32'h3C3C3C3C, 2'd1},
        // R5: 32, negative
        '{32'hFFFFFFF0, 32'hF0F0F0F0, 1'b0, 32'h0, 12'd32, 32'hFFFFFFFF, 32'hFFFFFFF0, 2'd1},
        // R5: 32, positive
        '{32'h0000000F, 32'h00000000, 1'b0, 32'h0, 12'd32, 32'h00000000, 32'h0000000F, 2'd2},
        // R5: 63, negative
        '{32'h80000000, 32'h00000000, 1'b0, 32'h0, 12'd63, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'd1},
        // R5 R6: 63, positive becomes zero
        '{32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0, 32'h0, 12'd63, 32'h00000000, 32'h00000000, 2'd0},
        // R2: base 8 + disp 0
        '{32'h12345678, 32'h9ABCDEF0, 1'b1, 32'd8, 12'd0,  32'h00123456, 32'h789ABCDE, 2'd2},
        // R3: disp 0xFC4, high bits ignored, count 4
        '{32'h00000000, 32'h000000F0, 1'b0, 32'h0, 12'hFC4, 32'h00000000, 32'h0000000F, 2'd2},
        // R2: wrap, all ones + 5 gives count 4
        '{32'h00000000, 32'h00000100, 1'b1, 32'hFFFFFFFF, 12'd5, 32'h00000000, 32'h00000010, 2'd2},
        // R2: 60 + 8 = 68, count 4
        '{32'hF0000000, 32'h00000000, 1'b1, 32'd60, 12'd8, 32'hFF000000, 32'h00000000, 2'd1},
        // R6 R1: zero operand
        '{32'h00000000, 32'h00000000, 1'b0, 32'h0, 12'd0,  32'h00000000, 32'h00000000, 2'd0},
        // R3: base value present on pins but flag low
        '{32'h00000000, 32'h00000002, 1'b0, 32'h10, 12'd1, 32'h00000000, 32'h00000001, 2'd2},
        // R5: count 33
        '{32'h80000001, 32'h00000000, 1'b0, 32'h0, 12'd33, 32'hFFFFFFFF, 32'hC0000000, 2'd1},
        // R1: count 31 crosses the word boundary
        '{32'h00000001, 32'h80000000, 1'b0, 32'h0, 12'd31, 32'h00000000, 32'h00000003, 2'd2}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic odd, input logic [31:0] h, input logic [31:0] l,
                         input logic bp, input logic [31:0] b, input logic [11:0] d);
        @(negedge clk);
        reg_odd      = odd;
        hi_in        = h;
        lo_in        = l;
        base_present = bp;
        base_val     = b;
        disp         = d;
        start        = 1'b1;
        @(negedge clk);
        start        = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 done", 64'(done), 64'd0);
        chk("R9 spec_err", 64'(spec_err), 64'd0);
        chk("R9 result", {hi_out, lo_out}, 64'd0);
        chk("R9 cc", 64'(cc), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue(1'b0, TBL[i].hi, TBL[i].lo, TBL[i].bp, TBL[i].base, TBL[i].dsp);
            chk("R7 done pulse", 64'(done), 64'd1);
            chk("R1 R4 result", {hi_out, lo_out}, {TBL[i].ehi, TBL[i].elo});
            chk("R6 cc", 64'(cc), 64'(TBL[i].ecc));
            chk("R8 spec_err low", 64'(spec_err), 64'd0);
        end

        // R7: idle cycles keep the last result
        @(negedge clk);
        chk("R7 done drop", 64'(done), 64'd0);
        hi_in = 32'hDEADBEEF;
        disp  = 12'd7;
        @(negedge clk);
        chk("R7 hold result", {hi_out, lo_out}, {32'h00000000, 32'h00000003});
        chk("R7 hold cc", 64'(cc), 64'd2);

        // negative result to set cc=1 before the refused request
        issue(1'b0, 32'h80000000, 32'h0, 1'b0, 32'h0, 12'd4);
        chk("R6 cc before refuse", 64'(cc), 64'd1);

        // R8: odd register refused
        issue(1'b1, 32'h00000000, 32'h00000000, 1'b0, 32'h0, 12'd1);
        chk("R8 spec_err", 64'(spec_err), 64'd1);
        chk("R8 done", 64'(done), 64'd1);
        chk("R8 words unchanged", {hi_out, lo_out}, 64'd0);
        chk("R8 cc kept", 64'(cc), 64'd1);

        issue(1'b1, 32'h12345678, 32'h9ABCDEF0, 1'b1, 32'd8, 12'd0);
        chk("R8 words unchanged 2", {hi_out, lo_out}, {32'h12345678, 32'h9ABCDEF0});
        chk("R8 cc kept 2", 64'(cc), 64'd1);

        // R8: next even request clears the error
        issue(1'b0, 32'h00000000, 32'h00000040, 1'b0, 32'h0, 12'd6);
        chk("R8 spec_err cleared", 64'(spec_err), 64'd0);
        chk("R6 cc after clear", 64'(cc), 64'd2);
        chk("R4 after clear", {hi_out, lo_out}, 64'd1);

        // R9: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset again", {hi_out, lo_out}, 64'd0);
        chk("R9 cc again", 64'(cc), 64'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule